// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block models a 128-word by 16-bit non-volatile memory that is reached over a three-wire synchronous serial link: a select line, a serial clock and a serial data input, with one serial data output that has an output enable. The storage cells are a register array. A fast system clock samples the serial clock, so all serial edges are found inside the block. The programming time is a count of system clocks.

A host raises select and shifts in a frame. The frame is a start bit, a two-bit opcode and an eight-bit address field, sent most significant bit first and sampled on rising serial clock edges. Reads return the addressed word on the data output. Writes, erases and their bulk forms are held until select falls. That falling edge starts a timed programming cycle. While select is high again, the output shows whether that cycle has finished. A write-enable latch that keeps its value between commands guards every programming command.

Top module: `mw_eeprom`

## Requirements
- R1: A frame begins with the first 1 sampled on DI while select is high, and zeros before it are skipped. It continues with opcode bits [1:0] and then address bits A7..A0. Opcode 10 reads, 01 writes and 11 erases one word. Opcode 00 uses A7:A6 as a sub-command: 11 sets the write-enable latch, 00 clears it, 10 erases all words and 01 writes all words. A7 is not part of the word index, so addresses a and a+128 name the same word.
- R2: After the last address bit of a read, the output is a 0 dummy bit. Each following rising serial clock edge presents the next data bit, D15 first and D0 last. Later edges present 0.
- R3: A write takes 16 data bits, MSB first, after the address. The word is replaced by those bits with no prior erase once programming completes. Programming starts on the falling edge of select after the last data bit.
- R4: Erase sets the addressed word to 16'hFFFF and leaves the other words unchanged. Erase-all sets every word to 16'hFFFF. Both start on the falling edge of select after the last address bit.
- R5: Write-all takes 16 data bits and stores them in every word.
- R6: The write-enable latch is clear after reset. While it is clear, write, erase, erase-all and write-all change nothing and start no busy period. A read works whatever the state of the latch.
- R7: When select is low, the output enable is 0. When select is high outside a read's data phase, the output is 0 while programming is busy and 1 when the block is ready.
- R8: A programming cycle lasts PROG_CYCLES system clocks. Frames started while it is busy, including write-enable and write-disable, are ignored.
- R9: Lowering select part-way through a frame discards it. A rising serial clock edge after the last required bit of a programming command, before select falls, cancels that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output: read bits or ready/busy status |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
The falling edge of select does two jobs in the same system clock. It clears the frame registers, and it launches programming from the armed frame that those same registers still hold. The bench exercises this on every write, erase and bulk command. It judges the result from the contents read back later and from the number of clocks from the select edge to the ready status. A second overlap arises when a frame arrives while the program timer is running. The bench sends a write-disable during a busy period and then checks that a later write still takes effect.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HDR   = 3'd1,
        ST_DATA  = 3'd2,
        ST_READ  = 3'd3,
        ST_ARMED = 3'd4,
        ST_DONE  = 3'd5
    } mw_state_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK  = 2'b00;
    localparam logic [1:0] SUB_WRALL = 2'b01;
    localparam logic [1:0] SUB_ERALL = 2'b10;
    localparam logic [1:0] SUB_OPEN  = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int ADDR_BITS = 8,
    parameter int AW        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_s,
    input  logic             sck_s,
    input  logic             sdi_s,
    input  logic             busy,
    input  logic [WIDTH-1:0] rd_word,
    output logic [AW-1:0]    rd_addr,
    output logic             start,
    output logic             pg_bulk,
    output logic             pg_erase,
    output logic [AW-1:0]    pg_addr,
    output logic [WIDTH-1:0] pg_data,
    output logic             rd_active,
    output logic             rd_bit,
    output logic             wen
);
    localparam int HDR_W = 2 + ADDR_BITS;
    localparam int MAXN  = (HDR_W > WIDTH) ? HDR_W : WIDTH;
    localparam int CNT_W = $clog2(MAXN + 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        mw_state_e        st;
        logic [HDR_W-1:0] hdr;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] sh;
        logic             out_bit;
        logic             wen;
        logic             bulk;
        logic             erase;
        logic             sck_prev;
        logic             sel_prev;
    } frame_t;

    frame_t     r_d, r_q;
    logic [HDR_W-1:0] nh;
    logic [1:0] opc, sub;
    logic       sck_rise, sel_fall;

    always_comb begin
        r_d        = r_q;
        nh         = {r_q.hdr[HDR_W-2:0], sdi_s};
        opc        = nh[HDR_W-1 -: 2];
        sub        = nh[ADDR_BITS-1 -: 2];
        sck_rise   = sck_s & ~r_q.sck_prev;
        sel_fall   = ~sel_s & r_q.sel_prev;
        start      = sel_fall && (r_q.st == ST_ARMED);
        r_d.sck_prev = sck_s;
        r_d.sel_prev = sel_s;

        if (!sel_s) begin
            r_d.st      = ST_IDLE;
            r_d.hdr     = '0;
            r_d.cnt     = '0;
            r_d.sh      = '0;
            r_d.out_bit = 1'b0;
        end else if (sck_rise) begin
            case (r_q.st)
                ST_IDLE: begin
                    if (sdi_s && !busy) begin
                        r_d.st  = ST_HDR;
                        r_d.cnt = '0;
                    end
                end
                ST_HDR: begin
                    r_d.hdr = nh;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == HDR_LAST) begin
                        r_d.st = ST_DONE;
                        r_d.cnt = '0;
                        case (opc)
                            OPC_READ: begin
                                r_d.st      = ST_READ;
                                r_d.sh      = rd_word;
                                r_d.out_bit = 1'b0;
                            end
                            OPC_WRITE: begin
                                if (r_q.wen) begin
                                    r_d.st    = ST_DATA;
                                    r_d.bulk  = 1'b0;
                                    r_d.erase = 1'b0;
                                end
                            end
                            OPC_ERASE: begin
                                if (r_q.wen) begin
                                    r_d.st    = ST_ARMED;
                                    r_d.bulk  = 1'b0;
                                    r_d.erase = 1'b1;
                                end
                            end
                            default: begin
                                case (sub)
                                    SUB_OPEN: r_d.wen = 1'b1;
                                    SUB_LOCK: r_d.wen = 1'b0;
                                    SUB_ERALL: begin
                                        if (r_q.wen) begin
                                            r_d.st    = ST_ARMED;
                                            r_d.bulk  = 1'b1;
                                            r_d.erase = 1'b1;
                                        end
                                    end
                                    default: begin
                                        if (r_q.wen) begin
                                            r_d.st    = ST_DATA;
                                            r_d.bulk  = 1'b1;
                                            r_d.erase = 1'b0;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    r_d.sh  = {r_q.sh[WIDTH-2:0], sdi_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == DATA_LAST) r_d.st = ST_ARMED;
                end
                ST_READ: begin
                    r_d.out_bit = r_q.sh[WIDTH-1];
                    r_d.sh      = {r_q.sh[WIDTH-2:0], 1'b0};
                end
                ST_ARMED: r_d.st = ST_DONE;
                default:  r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign rd_addr   = nh[AW-1:0];
    assign pg_bulk   = r_q.bulk;
    assign pg_erase  = r_q.erase;
    assign pg_addr   = r_q.hdr[AW-1:0];
    assign pg_data   = r_q.sh;
    assign rd_active = (r_q.st == ST_READ);
    assign rd_bit    = r_q.out_bit;
    assign wen       = r_q.wen;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int WORDS       = 128,
    parameter int WIDTH       = 16,
    parameter int AW          = 7,
    parameter int PROG_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bulk,
    input  logic             erase,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word,
    output logic             busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [TW-1:0]    tmr;
        logic             bulk;
        logic             erase;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } prog_t;

    prog_t            p_d, p_q;
    logic             commit;
    logic [WIDTH-1:0] value;
    logic [WIDTH-1:0] mem_q [WORDS];

    always_comb begin
        p_d    = p_q;
        commit = p_q.busy && (p_q.tmr == '0);
        value  = p_q.erase ? {WIDTH{1'b1}} : p_q.data;
        if (start && !p_q.busy) begin
            p_d.busy  = 1'b1;
            p_d.tmr   = TW'(PROG_CYCLES - 1);
            p_d.bulk  = bulk;
            p_d.erase = erase;
            p_d.addr  = addr;
            p_d.data  = data;
        end else if (p_q.busy) begin
            if (commit) p_d.busy = 1'b0;
            else        p_d.tmr  = p_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < WORDS; i++) begin
                if (p_q.bulk || (AW'(i) == p_q.addr)) mem_q[i] <= value;
            end
        end
    end

    assign rd_word = mem_q[rd_addr];
    assign busy    = p_q.busy;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int WORDS       = 128,
    parameter int WIDTH       = 16,
    parameter int ADDR_BITS   = 8,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int AW = $clog2(WORDS);

    logic [2:0]       sync_q;
    logic             sel_s, sck_s, sdi_s;
    logic             busy_w, wen_w, rd_active_w, rd_bit_w;
    logic             start_w, bulk_w, erase_w;
    logic [AW-1:0]    rd_addr_w, pg_addr_w;
    logic [WIDTH-1:0] rd_word_w, pg_data_w;

    mw_sync #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sdi_i, sclk_i, sel_i}),
        .q(sync_q)
    );

    assign sel_s = sync_q[0];
    assign sck_s = sync_q[1];
    assign sdi_s = sync_q[2];

    mw_frame #(.WIDTH(WIDTH), .ADDR_BITS(ADDR_BITS), .AW(AW)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sel_s(sel_s), .sck_s(sck_s), .sdi_s(sdi_s),
        .busy(busy_w), .rd_word(rd_word_w), .rd_addr(rd_addr_w),
        .start(start_w), .pg_bulk(bulk_w), .pg_erase(erase_w),
        .pg_addr(pg_addr_w), .pg_data(pg_data_w),
        .rd_active(rd_active_w), .rd_bit(rd_bit_w), .wen(wen_w)
    );

    mw_store #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .bulk(bulk_w), .erase(erase_w),
        .addr(pg_addr_w), .data(pg_data_w),
        .rd_addr(rd_addr_w), .rd_word(rd_word_w), .busy(busy_w)
    );

    assign sdo_oe_o = sel_s;
    assign sdo_o    = rd_active_w ? rd_bit_w : ~busy_w;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int PROG_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic busy,
    input logic wen,
    input logic rd_active
);
    logic [31:0] busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 32'd1;
        else           busy_len_q <= '0;
    end

    // R7: select held low for several clocks leaves the output undriven
    assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !$past(sel_i) && !$past(sel_i, 2) && !$past(sel_i, 3)) |-> !sdo_oe_o);

    // R7: a driven output during programming shows busy
    assert_status_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && busy) |-> !sdo_o);

    // R8: each programming cycle lasts exactly PROG_CYCLES clocks
    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len_q == 32'(PROG_CYCLES)));

    // R8: no read data phase runs during programming
    assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_active);

    // R6: programming only begins with the enable latch set
    assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sdo_o(sdo_o),
    .sdo_oe_o(sdo_oe_o), .busy(busy_w), .wen(wen_w), .rd_active(rd_active_w)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int PROG = 200;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mw_eeprom #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    function automatic logic [15:0] pat(input int a);
        pat = 16'((a * 16'h1357) ^ 16'hA5C3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sbit(input logic b);
        sdi = b;
        wclk(H);
        sck = 1'b1;
        wclk(H);
        sck = 1'b0;
    endtask

    task automatic send(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic cs_on;
        sel = 1'b1;
        wclk(H);
    endtask

    task automatic cs_off;
        sel = 1'b0;
        sdi = 1'b0;
        wclk(2 * H);
    endtask

    task automatic wait_ready;
        cs_on;
        wclk(PROG + 20);
        cs_off;
    endtask

    task automatic cmd(input logic [1:0] opc, input logic [7:0] a);
        send(11, {21'd0, 1'b1, opc, a});
    endtask

    task automatic prog_cmd(input logic [1:0] opc, input logic [7:0] a,
                            input bit has_data, input logic [15:0] d, input bit extra);
        cs_on;
        cmd(opc, a);
        if (has_data) send(16, {16'd0, d});
        if (extra) sbit(1'b0);
        cs_off;
        wait_ready;
    endtask

    task automatic do_read(input logic [7:0] a, input int lead,
                           output logic [15:0] d, output logic dm);
        cs_on;
        for (int i = 0; i < lead; i++) sbit(1'b0);
        cmd(2'b10, a);
        @(negedge clk);
        dm = sdo;
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b0);
            @(negedge clk);
            d[i] = sdo;
        end
        sbit(1'b0);
        @(negedge clk);
        chk("R2 trailing bit", {31'd0, sdo}, 32'd0);
        cs_off;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic dm;
        do_read(a, 0, d, dm);
        chk("R2 dummy bit", {31'd0, dm}, 32'd0);
        chk(req, {16'd0, d}, {16'd0, exp});
    endtask

    task automatic set_wen(input bit on);
        cs_on;
        cmd(2'b00, on ? 8'hC0 : 8'h00);
        cs_off;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic dm;
        int n;
        wclk(10);
        rst_n = 1'b1;
        wclk(4);
        @(negedge clk);
        chk("R7 reset oe", {31'd0, sdo_oe}, 32'd0);

        cs_on;
        wclk(4);
        @(negedge clk);
        chk("R7 idle oe", {31'd0, sdo_oe}, 32'd1);
        chk("R7 idle ready", {31'd0, sdo}, 32'd1);
        cs_off;

        // R6: bulk erase with the latch clear after reset must not start
        prog_cmd(2'b00, 8'h80, 1'b0, 16'h0, 1'b0);
        set_wen(1'b1);
        prog_cmd(2'b00, 8'h80, 1'b0, 16'h0, 1'b0);
        read_chk("R4 erase-all", 8'd3, 16'hFFFF);

        // R6: locked write ignored, no busy status, read still works
        set_wen(1'b0);
        cs_on;
        cmd(2'b01, 8'd3);
        send(16, 32'hBEEF);
        cs_off;
        cs_on;
        wclk(10);
        @(negedge clk);
        chk("R6 no busy when locked", {31'd0, sdo}, 32'd1);
        cs_off;
        read_chk("R6 locked write ignored", 8'd3, 16'hFFFF);

        // R3 R1: sweep all words, A7 toggled on writes
        set_wen(1'b1);
        for (int a = 0; a < 128; a++)
            prog_cmd(2'b01, {a[0], 7'(a)}, 1'b1, pat(a), 1'b0);
        set_wen(1'b0);
        for (int a = 0; a < 128; a++)
            read_chk("R3 sweep", 8'(a), pat(a));

        // R7 R8: busy status, exact duration, WDS ignored while busy
        set_wen(1'b1);
        cs_on;
        cmd(2'b01, 8'd10);
        send(16, 32'h1111);
        sel = 1'b0;
        sdi = 1'b0;
        n = 0;
        repeat (4) begin @(posedge clk); n++; end
        #1 sel = 1'b1;
        wclk(6);
        n += 6;
        @(negedge clk);
        chk("R7 busy shows 0", {31'd0, sdo}, 32'd0);
        cmd(2'b00, 8'h00);
        n += 11 * 2 * H;
        forever begin
            @(negedge clk);
            if (sdo_oe && sdo) break;
            @(posedge clk);
            n++;
        end
        chk("R8 duration window", {31'd0, (n >= PROG) && (n <= PROG + 6)}, 32'd1);
        cs_off;
        prog_cmd(2'b01, 8'd11, 1'b1, 16'h2222, 1'b0);
        read_chk("R8 first write", 8'd10, 16'h1111);
        read_chk("R8 latch kept after WDS during busy", 8'd11, 16'h2222);

        // R4: single erase
        prog_cmd(2'b11, 8'd20, 1'b0, 16'h0, 1'b0);
        read_chk("R4 erased word", 8'd20, 16'hFFFF);
        read_chk("R4 neighbour", 8'd21, pat(21));

        // R9: extra clock cancels a write
        prog_cmd(2'b01, 8'd30, 1'b1, 16'h0F0F, 1'b1);
        read_chk("R9 cancelled write", 8'd30, pat(30));

        // R9: partial frame discarded by select low
        cs_on;
        send(7, 32'b1010000);
        cs_off;
        cs_on;
        wclk(4);
        @(negedge clk);
        chk("R9 no busy after partial", {31'd0, sdo}, 32'd1);
        cs_off;
        read_chk("R9 read after partial", 8'd31, pat(31));

        // R1: leading zeros before the start bit
        do_read(8'd40, 3, d, dm);
        chk("R1 leading zeros", {16'd0, d}, {16'd0, pat(40)});

        // R5: write-all
        prog_cmd(2'b00, 8'h55, 1'b1, 16'hC3A5, 1'b0);
        read_chk("R5 word 0", 8'd0, 16'hC3A5);
        read_chk("R5 word 77", 8'd77, 16'hC3A5);
        read_chk("R5 word 127", 8'd127, 16'hC3A5);

        // R6: erase-all locked
        set_wen(1'b0);
        prog_cmd(2'b00, 8'hBF, 1'b0, 16'h0, 1'b0);
        read_chk("R6 locked erase-all", 8'd0, 16'hC3A5);
        set_wen(1'b1);
        prog_cmd(2'b00, 8'h80, 1'b0, 16'h0, 1'b0);
        read_chk("R4 erase-all word 64", 8'd64, 16'hFFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule